// File: doc/BRIEF.md
# Pseudo-SRAM Standby Power Mode Controller

This block governs the low-power states of a refresh-based pseudo-static RAM. While the memory is deselected, a held-low mode strobe can move it into one of two states. In the first, only part of the array is refreshed. In the second, refresh stops completely. A small mode register selects the state to enter and, for partial refresh, how much of the array is kept and which end of it.

The block also tracks which parts of the word address space still hold trustworthy data. It runs the timed recovery after the refresh-off state, during which normal access is held off. The memory array, the refresh engine and burst reads belong to neighbouring logic.

Data validity is kept for coarse segments of the address space. Each segment is the top SEG_BITS of the address. A segment loses validity when refresh over it stops. It regains validity when a write to any word in that segment is accepted.

Top module: `psram_lp_ctrl`

## Requirements
- R1: After reset, pwr_state is 00 (normal), ready is 1, mode_q equals MR_RESET (default 8'h18), and q_valid is 0 for every address.
- R2: Mode register bit 4 at 0 selects the refresh-off state (pwr_state 10) whatever bit 3 holds.
- R3: A low-power state is entered only from normal state while sel is 0. lp_req_n must be sampled low on ENTER_CYC consecutive clock edges, and the state changes on the last of those edges. Any edge with lp_req_n high or sel 1 restarts the count.
- R4: In partial-refresh state (pwr_state 01), lp_req_n sampled high returns the block to normal on that same edge. The mode register keeps its contents.
- R5: In refresh-off state, lp_req_n sampled high moves the block to the wake state (pwr_state 11). The block stays there for exactly WAKE_CYC clock cycles with ready 0, then returns to normal with ready 1.
- R6: Leaving the refresh-off state reloads the mode register with MR_RESET.
- R7: A mode register write (mode_we) is taken only in normal state. Writes are ignored in partial-refresh, refresh-off and wake states.
- R8: Partial refresh is used when bit 4 is 1 and bit 3 is 0. Bit 2 picks the top end (1) or the bottom end (0), and bit 1 picks a quarter (1) or a half (0). In partial-refresh state, keep_lo and keep_hi give the kept word range, for example C00000h–FFFFFFh for a top quarter.
- R9: Entering partial refresh clears q_valid for every segment outside the kept range and leaves segments inside it unchanged. A later accepted write (wr_en with sel in normal state) makes its segment valid again.
- R10: Entering the refresh-off state clears q_valid for every address.
- R11: With bits 4 and 3 both 1, a held-low lp_req_n never leaves the normal state.
- R12: In refresh-off state keep_none is 1. In every other state it is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sel | input | 1 | Memory selected (active high); 0 means standby |
| lp_req_n | input | 1 | Low-power mode strobe, active low |
| mode_we | input | 1 | Mode register write request |
| mode_wdata | input | MR_W | Mode register write data |
| wr_en | input | 1 | Array write accepted by the memory (with sel) |
| wr_addr | input | ADDR_W | Word address of the array write |
| q_addr | input | ADDR_W | Address for the data-valid query |
| pwr_state | output | 2 | 00 normal, 01 partial refresh, 10 refresh off, 11 waking |
| ready | output | 1 | Normal access allowed |
| mode_q | output | MR_W | Current mode register contents |
| keep_lo | output | ADDR_W | Lowest retained word address |
| keep_hi | output | ADDR_W | Highest retained word address |
| keep_none | output | 1 | No address is retained |
| q_valid | output | 1 | Data at q_addr is valid |

## Verification
The bench builds the block with its default parameters. These are a 50 MHz clock figure, a 24-bit word address and four segment bits. With these values the entry interval is 25 cycles and the wake interval is 10000 cycles. Both intervals are short enough to be walked edge by edge, including the cycle before each transition. Sixteen segments put the half and quarter boundaries at segments 4, 8 and 12. This lets writes placed on both sides of each boundary show exactly which flags a partial-refresh entry clears.

// File: rtl/psram_lp_pkg.sv
package psram_lp_pkg;

   typedef enum logic [1:0] {
      PS_NORMAL  = 2'b00,
      PS_PARTIAL = 2'b01,
      PS_DEEP    = 2'b10,
      PS_WAKE    = 2'b11
   } pwr_state_e;

   // Mode register bit positions that the controller decodes
   localparam int MRB_DPD_OFF = 4;
   localparam int MRB_PAR_OFF = 3;
   localparam int MRB_TOP     = 2;
   localparam int MRB_QUARTER = 1;

   function automatic int cycles_from_ns(int clk_khz, int ns);
      longint prod;
      prod = longint'(clk_khz) * longint'(ns);
      return int'((prod + 64'd999_999) / 64'd1_000_000);
   endfunction

   function automatic int cycles_from_us(int clk_khz, int us);
      longint prod;
      prod = longint'(clk_khz) * longint'(us);
      return int'((prod + 64'd999) / 64'd1_000);
   endfunction

endpackage

// File: rtl/psram_lp_timer.sv
module psram_lp_timer #(
   parameter int LIMIT = 25
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic done
);
   localparam int CW = $clog2(LIMIT + 1);

   if (LIMIT < 1) begin : g_bad_limit
      $error("psram_lp_timer: LIMIT must be at least 1");
   end

   logic [CW-1:0] cnt;

   assign done = run && (cnt == CW'(LIMIT - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)             cnt <= '0;
      else if (!run || done)  cnt <= '0;
      else                    cnt <= cnt + 1'b1;
   end

   AST_TIMER_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= CW'(LIMIT - 1)); // R5

endmodule

// File: rtl/psram_lp_fsm.sv
module psram_lp_fsm
   import psram_lp_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       sel,
   input  logic       lp_req_n,
   input  logic       dpd_off,
   input  logic       par_off,
   input  logic       enter_done,
   input  logic       wake_done,
   output pwr_state_e st,
   output logic       enter_run,
   output logic       wake_run,
   output logic       ev_par,
   output logic       ev_dpd,
   output logic       ev_dpd_exit
);
   pwr_state_e st_nxt;

   assign enter_run   = (st == PS_NORMAL) && !sel && !lp_req_n;
   assign wake_run    = (st == PS_WAKE);
   assign ev_dpd      = (st == PS_NORMAL) && enter_done && !dpd_off;
   assign ev_par      = (st == PS_NORMAL) && enter_done && dpd_off && !par_off;
   assign ev_dpd_exit = (st == PS_DEEP) && lp_req_n;

   always_comb begin
      st_nxt = st;
      unique case (st)
         PS_NORMAL: begin
            if (ev_dpd)      st_nxt = PS_DEEP;
            else if (ev_par) st_nxt = PS_PARTIAL;
         end
         PS_PARTIAL: if (lp_req_n)  st_nxt = PS_NORMAL;
         PS_DEEP:    if (lp_req_n)  st_nxt = PS_WAKE;
         PS_WAKE:    if (wake_done) st_nxt = PS_NORMAL;
         default:                   st_nxt = PS_NORMAL;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st <= PS_NORMAL;
      else        st <= st_nxt;
   end

   AST_ENTRY_FROM_STANDBY: assert property (@(posedge clk) disable iff (!rst_n)
      ((st == PS_PARTIAL || st == PS_DEEP) && $past(st) == PS_NORMAL)
      |-> (!$past(sel) && !$past(lp_req_n))); // R3

   AST_DEEP_PRIORITY: assert property (@(posedge clk) disable iff (!rst_n)
      (st == PS_PARTIAL && $past(st) == PS_NORMAL) |-> $past(dpd_off)); // R2

   AST_PARTIAL_EXIT_FAST: assert property (@(posedge clk) disable iff (!rst_n)
      (st == PS_PARTIAL && lp_req_n) |=> (st == PS_NORMAL)); // R4

endmodule

// File: rtl/psram_lp_modereg.sv
module psram_lp_modereg
   import psram_lp_pkg::*;
#(
   parameter int             MR_W    = 8,
   parameter logic [MR_W-1:0] MR_RESET = 8'h18
) (
   input  logic            clk,
   input  logic            rst_n,
   input  pwr_state_e      st,
   input  logic            we,
   input  logic [MR_W-1:0] wdata,
   input  logic            reload,
   output logic [MR_W-1:0] mr
);
   if (MR_W < 5) begin : g_bad_width
      $error("psram_lp_modereg: MR_W must hold bits 4..1");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                        mr <= MR_RESET;
      else if (reload)                   mr <= MR_RESET;
      else if (we && st == PS_NORMAL)    mr <= wdata;
   end

   AST_MODE_FROZEN_LOWPWR: assert property (@(posedge clk) disable iff (!rst_n)
      (st == PS_PARTIAL || st == PS_WAKE || (st == PS_DEEP && !reload))
      |=> $stable(mr)); // R7

   AST_MODE_RELOADED: assert property (@(posedge clk) disable iff (!rst_n)
      reload |=> (mr == MR_RESET)); // R6

endmodule

// File: rtl/psram_lp_window.sv
module psram_lp_window
   import psram_lp_pkg::*;
#(
   parameter int ADDR_W   = 24,
   parameter int SEG_BITS = 4
) (
   input  pwr_state_e                  st,
   input  logic                        top,
   input  logic                        quarter,
   output logic [ADDR_W-1:0]           keep_lo,
   output logic [ADDR_W-1:0]           keep_hi,
   output logic                        keep_none,
   output logic [(1<<SEG_BITS)-1:0]    seg_keep
);
   localparam int NSEG = 1 << SEG_BITS;
   localparam logic [ADDR_W-1:0] HALF_LO = {1'b1,  {(ADDR_W-1){1'b0}}};
   localparam logic [ADDR_W-1:0] QTR_LO  = {2'b11, {(ADDR_W-2){1'b0}}};
   localparam logic [ADDR_W-1:0] ALL_ONE = {ADDR_W{1'b1}};

   if (SEG_BITS < 2 || SEG_BITS > ADDR_W) begin : g_bad_seg
      $error("psram_lp_window: SEG_BITS must lie in 2..ADDR_W");
   end

   // Per-segment membership of the partial-refresh window
   for (genvar s = 0; s < NSEG; s++) begin : g_seg
      localparam logic [1:0] TOP2 = 2'(s >> (SEG_BITS - 2));
      logic in_half, in_qtr;
      assign in_half     = top ? TOP2[1]          : !TOP2[1];
      assign in_qtr      = top ? (TOP2 == 2'b11)  : (TOP2 == 2'b00);
      assign seg_keep[s] = quarter ? in_qtr : in_half;
   end

   always_comb begin
      keep_none = 1'b0;
      keep_lo   = '0;
      keep_hi   = ALL_ONE;
      unique case (st)
         PS_PARTIAL: begin
            if (quarter) begin
               keep_lo = top ? QTR_LO : '0;
               keep_hi = top ? ALL_ONE : ~QTR_LO;
            end else begin
               keep_lo = top ? HALF_LO : '0;
               keep_hi = top ? ALL_ONE : ~HALF_LO;
            end
         end
         PS_DEEP: begin
            keep_none = 1'b1;
            keep_hi   = '0;
         end
         default: ;
      endcase
   end

endmodule

// File: rtl/psram_lp_validmap.sv
module psram_lp_validmap #(
   parameter int ADDR_W   = 24,
   parameter int SEG_BITS = 4
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      wr_hit,
   input  logic [ADDR_W-1:0]         wr_addr,
   input  logic                      ev_par,
   input  logic                      ev_dpd,
   input  logic [(1<<SEG_BITS)-1:0]  seg_keep,
   input  logic [ADDR_W-1:0]         q_addr,
   output logic                      q_valid
);
   localparam int NSEG = 1 << SEG_BITS;

   if (SEG_BITS > 10) begin : g_bad_map
      $error("psram_lp_validmap: SEG_BITS too large for a flag map");
   end

   logic [NSEG-1:0]     flags, flags_nxt;
   logic [SEG_BITS-1:0] wr_seg, q_seg;

   assign wr_seg = wr_addr[ADDR_W-1 -: SEG_BITS];
   assign q_seg  = q_addr[ADDR_W-1 -: SEG_BITS];

   for (genvar s = 0; s < NSEG; s++) begin : g_flag
      always_comb begin
         if (ev_dpd || (ev_par && !seg_keep[s]))
            flags_nxt[s] = 1'b0;
         else if (wr_hit && wr_seg == SEG_BITS'(s))
            flags_nxt[s] = 1'b1;
         else
            flags_nxt[s] = flags[s];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flags <= '0;
      else        flags <= flags_nxt;
   end

   assign q_valid = flags[q_seg];

   AST_DEEP_WIPES_ALL: assert property (@(posedge clk) disable iff (!rst_n)
      ev_dpd |=> (flags == '0)); // R10

   AST_PARTIAL_DROPS_OUTSIDE: assert property (@(posedge clk) disable iff (!rst_n)
      ev_par |=> ((flags & ~$past(seg_keep)) == '0)); // R9

endmodule

// File: rtl/psram_lp_ctrl.sv
module psram_lp_ctrl
   import psram_lp_pkg::*;
#(
   parameter int              CLK_KHZ  = 50_000,
   parameter int              ENTER_NS = 500,
   parameter int              WAKE_US  = 200,
   parameter int              ADDR_W   = 24,
   parameter int              SEG_BITS = 4,
   parameter int              MR_W     = 8,
   parameter logic [MR_W-1:0] MR_RESET = 8'h18
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sel,
   input  logic              lp_req_n,
   input  logic              mode_we,
   input  logic [MR_W-1:0]   mode_wdata,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [ADDR_W-1:0] q_addr,
   output logic [1:0]        pwr_state,
   output logic              ready,
   output logic [MR_W-1:0]   mode_q,
   output logic [ADDR_W-1:0] keep_lo,
   output logic [ADDR_W-1:0] keep_hi,
   output logic              keep_none,
   output logic              q_valid
);
   localparam int ENTER_CYC = cycles_from_ns(CLK_KHZ, ENTER_NS);
   localparam int WAKE_CYC  = cycles_from_us(CLK_KHZ, WAKE_US);
   localparam int NSEG      = 1 << SEG_BITS;

   if (ENTER_CYC < 1 || WAKE_CYC < 1) begin : g_bad_timing
      $error("psram_lp_ctrl: clock too slow for the timed intervals");
   end

   pwr_state_e      st;
   logic            enter_run, wake_run, enter_done, wake_done;
   logic            ev_par, ev_dpd, ev_dpd_exit;
   logic [MR_W-1:0] mr;
   logic [NSEG-1:0] seg_keep;
   logic            wr_hit;

   psram_lp_timer #(.LIMIT(ENTER_CYC)) u_enter_tmr (
      .clk(clk), .rst_n(rst_n), .run(enter_run), .done(enter_done));

   psram_lp_timer #(.LIMIT(WAKE_CYC)) u_wake_tmr (
      .clk(clk), .rst_n(rst_n), .run(wake_run), .done(wake_done));

   psram_lp_fsm u_fsm (
      .clk(clk), .rst_n(rst_n), .sel(sel), .lp_req_n(lp_req_n),
      .dpd_off(mr[MRB_DPD_OFF]), .par_off(mr[MRB_PAR_OFF]),
      .enter_done(enter_done), .wake_done(wake_done), .st(st),
      .enter_run(enter_run), .wake_run(wake_run),
      .ev_par(ev_par), .ev_dpd(ev_dpd), .ev_dpd_exit(ev_dpd_exit));

   psram_lp_modereg #(.MR_W(MR_W), .MR_RESET(MR_RESET)) u_mode (
      .clk(clk), .rst_n(rst_n), .st(st), .we(mode_we), .wdata(mode_wdata),
      .reload(ev_dpd_exit), .mr(mr));

   psram_lp_window #(.ADDR_W(ADDR_W), .SEG_BITS(SEG_BITS)) u_win (
      .st(st), .top(mr[MRB_TOP]), .quarter(mr[MRB_QUARTER]),
      .keep_lo(keep_lo), .keep_hi(keep_hi), .keep_none(keep_none),
      .seg_keep(seg_keep));

   assign wr_hit = wr_en && sel && (st == PS_NORMAL);

   psram_lp_validmap #(.ADDR_W(ADDR_W), .SEG_BITS(SEG_BITS)) u_valid (
      .clk(clk), .rst_n(rst_n), .wr_hit(wr_hit), .wr_addr(wr_addr),
      .ev_par(ev_par), .ev_dpd(ev_dpd), .seg_keep(seg_keep),
      .q_addr(q_addr), .q_valid(q_valid));

   assign pwr_state = st;
   assign ready     = (st == PS_NORMAL);
   assign mode_q    = mr;

endmodule

// File: tb/tb_psram_lp_ctrl.sv
module tb_psram_lp_ctrl;
   localparam int ENTER = 25;     // 0.5 us at 50 MHz
   localparam int WAKE  = 10000;  // 200 us at 50 MHz

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        sel = 1'b0, lp_req_n = 1'b1, mode_we = 1'b0, wr_en = 1'b0;
   logic [7:0]  mode_wdata = '0;
   logic [23:0] wr_addr = '0, q_addr = '0;
   logic [1:0]  pwr_state;
   logic        ready, keep_none, q_valid;
   logic [7:0]  mode_q;
   logic [23:0] keep_lo, keep_hi;

   int checks = 0;
   int fails  = 0;

   always #10 clk = ~clk;

   psram_lp_ctrl dut (
      .clk(clk), .rst_n(rst_n), .sel(sel), .lp_req_n(lp_req_n),
      .mode_we(mode_we), .mode_wdata(mode_wdata), .wr_en(wr_en),
      .wr_addr(wr_addr), .q_addr(q_addr), .pwr_state(pwr_state),
      .ready(ready), .mode_q(mode_q), .keep_lo(keep_lo), .keep_hi(keep_hi),
      .keep_none(keep_none), .q_valid(q_valid));

   task automatic step(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic mode_write(logic [7:0] v);
      mode_we = 1'b1; mode_wdata = v;
      step(1);
      mode_we = 1'b0;
   endtask

   task automatic mem_write(logic [23:0] a);
      sel = 1'b1; wr_en = 1'b1; wr_addr = a;
      step(1);
      wr_en = 1'b0; sel = 1'b0;
   endtask

   task automatic query(logic [23:0] a, logic exp, string req);
      q_addr = a;
      #1;
      chk(req, $sformatf("q_valid@%06h", a), q_valid, exp);
   endtask

   task automatic t_reset;
      chk("R1", "pwr_state", pwr_state, 2'b00);
      chk("R1", "ready", ready, 1'b1);
      chk("R1", "mode_q", mode_q, 8'h18);
      query(24'h000000, 1'b0, "R1");
      query(24'hFFFFFF, 1'b0, "R1");
   endtask

   task automatic t_no_mode;
      lp_req_n = 1'b0;
      step(3 * ENTER);
      chk("R11", "pwr_state", pwr_state, 2'b00);
      chk("R11", "ready", ready, 1'b1);
      lp_req_n = 1'b1;
      step(1);
   endtask

   task automatic t_par_quarter_top;
      mode_write(8'h16);
      chk("R7", "mode_q normal write", mode_q, 8'h16);
      mem_write(24'h000010);
      mem_write(24'h500000);
      mem_write(24'hC00020);
      mem_write(24'hFFFFF0);
      query(24'h500000, 1'b1, "R9");
      // strobe released one edge short of the interval restarts the count
      lp_req_n = 1'b0; step(ENTER - 1);
      chk("R3", "pwr_state before interval", pwr_state, 2'b00);
      lp_req_n = 1'b1; step(1);
      lp_req_n = 1'b0; step(ENTER - 1);
      chk("R3", "pwr_state after restart", pwr_state, 2'b00);
      step(1);
      chk("R3", "pwr_state entered", pwr_state, 2'b01);
      chk("R8", "keep_lo quarter top", keep_lo, 24'hC00000);
      chk("R8", "keep_hi quarter top", keep_hi, 24'hFFFFFF);
      chk("R12", "keep_none partial", keep_none, 1'b0);
      mode_write(8'h18);
      chk("R7", "mode_q partial write ignored", mode_q, 8'h16);
      query(24'h000010, 1'b0, "R9");
      query(24'h500000, 1'b0, "R9");
      query(24'hC00020, 1'b1, "R9");
      query(24'hFFFFF0, 1'b1, "R9");
      lp_req_n = 1'b1; step(1);
      chk("R4", "pwr_state exit", pwr_state, 2'b00);
      chk("R4", "ready exit", ready, 1'b1);
      chk("R4", "mode_q kept", mode_q, 8'h16);
   endtask

   task automatic t_par_half_bottom;
      mode_write(8'h10);
      mem_write(24'h200000);
      mem_write(24'h900000);
      lp_req_n = 1'b0; step(ENTER - 1);
      sel = 1'b1; step(1);
      sel = 1'b0; step(ENTER - 1);
      chk("R3", "pwr_state after select", pwr_state, 2'b00);
      step(1);
      chk("R3", "pwr_state entered half", pwr_state, 2'b01);
      chk("R8", "keep_lo half bottom", keep_lo, 24'h000000);
      chk("R8", "keep_hi half bottom", keep_hi, 24'h7FFFFF);
      lp_req_n = 1'b1; step(1);
      chk("R4", "pwr_state half exit", pwr_state, 2'b00);
      query(24'h200000, 1'b1, "R9");
      query(24'h900000, 1'b0, "R9");
      mem_write(24'h900000);
      query(24'h900000, 1'b1, "R9");
   endtask

   task automatic t_deep;
      mode_write(8'h06);
      mem_write(24'h100000);
      query(24'h100000, 1'b1, "R10");
      lp_req_n = 1'b0; step(ENTER);
      chk("R2", "pwr_state deep wins", pwr_state, 2'b10);
      chk("R12", "keep_none deep", keep_none, 1'b1);
      chk("R5", "ready deep", ready, 1'b0);
      query(24'h100000, 1'b0, "R10");
      query(24'hF00000, 1'b0, "R10");
      mode_write(8'h16);
      chk("R7", "mode_q deep write ignored", mode_q, 8'h06);
      lp_req_n = 1'b1; step(1);
      chk("R5", "pwr_state wake", pwr_state, 2'b11);
      chk("R5", "ready wake", ready, 1'b0);
      chk("R6", "mode_q reloaded", mode_q, 8'h18);
      chk("R12", "keep_none wake", keep_none, 1'b0);
      mode_write(8'h16);
      step(WAKE - 2);
      chk("R5", "pwr_state last wake cycle", pwr_state, 2'b11);
      chk("R5", "ready last wake cycle", ready, 1'b0);
      step(1);
      chk("R5", "pwr_state after wake", pwr_state, 2'b00);
      chk("R5", "ready after wake", ready, 1'b1);
      chk("R7", "mode_q wake write ignored", mode_q, 8'h18);
      mode_write(8'h16);
      chk("R7", "mode_q write after wake", mode_q, 8'h16);
   endtask

   initial begin
      step(3);
      rst_n = 1'b1;
      step(1);
      t_reset();
      t_no_mode();
      t_par_quarter_top();
      t_par_half_bottom();
      t_deep();
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      #(200000 * 20);
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

endmodule